// File: doc/BRIEF.md
# NAND Single-Operation Engine

This block sits between a host register bus and a raw NAND flash bus and carries out one elementary flash bus operation per request. Software first loads the command byte or the address byte into its own 16-bit register, selects the target chip and buffer slot, and then writes a one-hot request into the operation register. The engine runs the requested bus cycle, with the latch enables, write or read strobes and data bus driven for a parameterised number of clocks. It then sets a sticky completion flag and, unless masked, raises an interrupt.

The supported operations are a command latch, a single address byte, page data in (a small stub pattern is written out), page data out, ID read and status read. The last byte that a read operation captures is exposed in a read-data register. The flash ready/busy line is synchronised inside the block. Operations that start internal flash activity (command, page in, page out) report completion only once that line is high again. A self-clearing soft reset returns the sequencer to idle without losing configuration.

The sequencer states are S_IDLE, S_SETUP, S_LOW, S_HIGH, S_WAIT_RB and S_DONE. A request moves S_IDLE to S_SETUP, where latch enables and data are driven with the strobe high. S_SETUP always goes to S_LOW, where the strobe is held low for STROBE_CLKS clocks. S_LOW goes to S_HIGH, where the strobe rises with data held. S_HIGH returns to S_SETUP while bytes remain. After the last byte, S_HIGH goes to S_WAIT_RB for waiting operations and to S_DONE for the others. S_WAIT_RB waits a guard time and then for ready, and moves to S_DONE. S_DONE pulses completion and returns to S_IDLE. A soft reset forces S_IDLE from any state.

Top module: `nand_op_engine`

Register offsets (reg_addr): 0 command, 1 address, 2 buffer select, 3 operation, 4 configuration, 5 read data.

## Requirements
- R1: After reset the operation and configuration registers read 0, nf_ce_n, nf_we_n and nf_re_n are high, and irq is low.
- R2: Operation bit 0 emits exactly one write strobe with nf_cle high, nf_ale low and the low byte of the command register on nf_dq_o.
- R3: Operation bit 1 emits exactly one write strobe with nf_ale high, nf_cle low and the low byte of the address register; nf_cle and nf_ale are never high together.
- R4: When one write to the operation register sets several of bits 5:0, only the lowest-numbered set bit runs.
- R5: While an operation runs, the operation register reads back the one-hot bit of the running operation. Every register write during that time is ignored, except that setting configuration bit 6 still starts a soft reset.
- R6: Operation register bit 15 sets when an operation ends, and in the same cycle bits 5:0 clear. The flag stays set until an accepted write to the operation register carries 0 in bit 15; a write with 1 in bit 15 leaves it set.
- R7: irq is high exactly while the completion flag is set and configuration bit 4 (mask) is 0; the mask does not stop the flag from setting.
- R8: Setting configuration bit 6 returns the sequencer to idle and clears the completion flag and the operation bits. Bit 6 then clears by itself after SRST_CLKS clocks, and the other configuration bits are kept.
- R9: Configuration bit 7 drives nf_ce_n low. Buffer-select bits 6:5 appear on nf_cs, and buffer-select bits 2:0 read back in place.
- R10: Command, page-in and page-out operations set the completion flag only after nf_rb_n has been seen high following the last strobe; address, ID and status operations do not wait.
- R11: Page in (bit 2) emits PAGE_BYTES write strobes carrying {buffer index, byte number[4:0]}. Page out (bit 3), ID read (bit 4) and status read (bit 5) issue PAGE_BYTES, ID_BYTES and one read strobe respectively, and read-data register bits 7:0 hold the byte sampled on the last one.
- R12: Every write or read strobe stays low for exactly STROBE_CLKS clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Completion interrupt, active high |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cs | output | 2 | Active chip-select index |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, data latched on rising edge |
| nf_re_n | output | 1 | Read strobe |
| nf_dq_o | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_i | input | 8 | Flash data in |
| nf_rb_n | input | 1 | Flash ready/busy, high when ready |

## Verification
A sequencer left in the wrong state shows within one strobe time as an extra, missing or mislabelled strobe on the flash bus. Every write strobe is matched against an expected latch-enable and data item, so a wrong operation choice or byte count shows at once. A wrong completion path shows as the flag setting while ready/busy is still held low, or as stale operation bits after the flag rises. A soft reset that leaks state shows as a nonzero operation register or an unexpected strobe after the reset bit self-clears.

// File: rtl/nand_eng_pkg.sv
`timescale 1ns/1ps
package nand_eng_pkg;
    typedef enum logic [2:0] {
        OP_CMD  = 3'd0,
        OP_ADR  = 3'd1,
        OP_DIN  = 3'd2,
        OP_DOUT = 3'd3,
        OP_ID   = 3'd4,
        OP_STAT = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_LOW, S_HIGH, S_WAIT_RB, S_DONE
    } state_e;

    localparam int NUM_OPS = 6;

    localparam logic [2:0] A_CMD  = 3'd0;
    localparam logic [2:0] A_ADR  = 3'd1;
    localparam logic [2:0] A_BUF  = 3'd2;
    localparam logic [2:0] A_TRIG = 3'd3;
    localparam logic [2:0] A_CFG  = 3'd4;
    localparam logic [2:0] A_RX   = 3'd5;
endpackage

// File: rtl/nand_eng_regs.sv
`timescale 1ns/1ps
module nand_eng_regs
    import nand_eng_pkg::*;
#(
    parameter int SRST_CLKS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_addr,
    input  logic [15:0]         reg_wdata,
    input  logic                busy_i,
    input  logic                op_done_i,
    output logic [15:0]         cmd_q,
    output logic [15:0]         adr_q,
    output logic [1:0]          cs_q,
    output logic [2:0]          idx_q,
    output logic [7:0]          cfg_q,
    output logic [NUM_OPS-1:0]  ops_q,
    output logic                done_q,
    output logic                start_o,
    output op_e                 op_o,
    output logic                clr_o
);
    localparam int SW = $clog2(SRST_CLKS + 1);

    logic              acc;
    logic [SW-1:0]     srst_cnt;
    logic [NUM_OPS-1:0] sel_hot;
    logic              found;

    assign acc     = reg_wr && !busy_i && !cfg_q[6];
    assign start_o = acc && (reg_addr == A_TRIG) && (|reg_wdata[NUM_OPS-1:0]);
    assign clr_o   = cfg_q[6];

    // lowest set request bit wins
    always_comb begin
        sel_hot = '0;
        op_o    = OP_CMD;
        found   = 1'b0;
        for (int i = 0; i < NUM_OPS; i++) begin
            if (reg_wdata[i] && !found) begin
                sel_hot[i] = 1'b1;
                op_o       = op_e'(i[2:0]);
                found      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            adr_q    <= '0;
            cs_q     <= '0;
            idx_q    <= '0;
            cfg_q    <= '0;
            ops_q    <= '0;
            done_q   <= 1'b0;
            srst_cnt <= '0;
        end else begin
            if (acc) begin
                case (reg_addr)
                    A_CMD: cmd_q <= reg_wdata;
                    A_ADR: adr_q <= reg_wdata;
                    A_BUF: begin
                        cs_q  <= reg_wdata[6:5];
                        idx_q <= reg_wdata[2:0];
                    end
                    A_CFG: cfg_q <= reg_wdata[7:0];
                    A_TRIG: done_q <= done_q & reg_wdata[15];
                    default: ;
                endcase
            end else if (reg_wr && reg_addr == A_CFG && reg_wdata[6]) begin
                cfg_q[6] <= 1'b1;
            end
            if (start_o) ops_q <= sel_hot;
            if (op_done_i) begin
                done_q <= 1'b1;
                ops_q  <= '0;
            end
            if (cfg_q[6]) begin
                ops_q    <= '0;
                done_q   <= 1'b0;
                srst_cnt <= srst_cnt + 1'b1;
                if (srst_cnt == SW'(SRST_CLKS - 1)) begin
                    cfg_q[6] <= 1'b0;
                    srst_cnt <= '0;
                end
            end
        end
    end

    // R5
    regs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(cmd_q) && $stable(adr_q) && $stable(idx_q)));

    // R6
    flag_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_i |=> (done_q && ops_q == '0));

    // R8
    srst_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_q[6]) |-> (!done_q && ops_q == '0));
endmodule

// File: rtl/nand_eng_fsm.sv
`timescale 1ns/1ps
module nand_eng_fsm
    import nand_eng_pkg::*;
#(
    parameter int PAGE_BYTES  = 8,
    parameter int ID_BYTES    = 4,
    parameter int STROBE_CLKS = 3,
    parameter int TWB_CLKS    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       start,
    input  op_e        op_in,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] adr_byte,
    input  logic [2:0] buf_idx,
    input  logic       rb_n,
    input  logic [7:0] dq_i,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic       dq_oe,
    output logic [7:0] dq_o,
    output logic       busy,
    output logic       op_done,
    output logic [7:0] rx_byte
);
    localparam int MAXB = (PAGE_BYTES > ID_BYTES) ? PAGE_BYTES : ID_BYTES;
    localparam int CW   = $clog2(MAXB + 1);
    localparam int MAXT = (STROBE_CLKS > TWB_CLKS) ? STROBE_CLKS : TWB_CLKS;
    localparam int TW   = $clog2(MAXT + 1) + 1;

    state_e        state_q;
    op_e           op_q;
    logic [CW-1:0] byte_q;
    logic [TW-1:0] tim_q;
    logic          rb_meta, rb_q;
    logic          is_read, needs_wait, last_byte, active;
    logic [CW-1:0] nbytes;

    always_comb begin
        unique case (op_q)
            OP_DIN, OP_DOUT: nbytes = CW'(PAGE_BYTES);
            OP_ID:           nbytes = CW'(ID_BYTES);
            default:         nbytes = CW'(1);
        endcase
    end

    assign is_read    = (op_q == OP_DOUT) || (op_q == OP_ID) || (op_q == OP_STAT);
    assign needs_wait = (op_q == OP_CMD) || (op_q == OP_DIN) || (op_q == OP_DOUT);
    assign last_byte  = (byte_q == nbytes - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_meta <= 1'b1;
            rb_q    <= 1'b1;
        end else begin
            rb_meta <= rb_n;
            rb_q    <= rb_meta;
        end
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_CMD;
            byte_q  <= '0;
            tim_q   <= '0;
            rx_byte <= '0;
        end else if (clr) begin
            state_q <= S_IDLE;
            byte_q  <= '0;
            tim_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    op_q    <= op_in;
                    byte_q  <= '0;
                    state_q <= S_SETUP;
                end
                S_SETUP: begin
                    tim_q   <= '0;
                    state_q <= S_LOW;
                end
                S_LOW: begin
                    if (tim_q == TW'(STROBE_CLKS - 1)) begin
                        if (is_read) rx_byte <= dq_i;
                        state_q <= S_HIGH;
                    end else begin
                        tim_q <= tim_q + 1'b1;
                    end
                end
                S_HIGH: begin
                    if (last_byte) begin
                        tim_q   <= '0;
                        state_q <= needs_wait ? S_WAIT_RB : S_DONE;
                    end else begin
                        byte_q  <= byte_q + 1'b1;
                        state_q <= S_SETUP;
                    end
                end
                S_WAIT_RB: begin
                    if (tim_q < TW'(TWB_CLKS)) tim_q <= tim_q + 1'b1;
                    else if (rb_q)             state_q <= S_DONE;
                end
                S_DONE: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        active  = (state_q == S_SETUP) || (state_q == S_LOW) || (state_q == S_HIGH);
        cle     = active && (op_q == OP_CMD);
        ale     = active && (op_q == OP_ADR);
        dq_oe   = active && !is_read;
        we_n    = !((state_q == S_LOW) && !is_read);
        re_n    = !((state_q == S_LOW) && is_read);
        busy    = (state_q != S_IDLE);
        op_done = (state_q == S_DONE);
        unique case (op_q)
            OP_CMD:  dq_o = cmd_byte;
            OP_ADR:  dq_o = adr_byte;
            OP_DIN:  dq_o = {buf_idx, 5'(byte_q)};
            default: dq_o = 8'h00;
        endcase
    end

    // strobe width monitor
    logic [TW:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                low_run <= '0;
        else if (!we_n || !re_n)   low_run <= low_run + 1'b1;
        else                       low_run <= '0;
    end

    // R12
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n) || $rose(re_n)) |-> (low_run == (TW+1)'(STROBE_CLKS)));

    // R3
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cle, ale}));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n || re_n));

    // R10
    rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state_q == S_WAIT_RB && !rb_q) |=> (state_q != S_DONE));
endmodule

// File: rtl/nand_op_engine.sv
`timescale 1ns/1ps
module nand_op_engine
    import nand_eng_pkg::*;
#(
    parameter int PAGE_BYTES  = 8,
    parameter int ID_BYTES    = 4,
    parameter int STROBE_CLKS = 3,
    parameter int TWB_CLKS    = 2,
    parameter int SRST_CLKS   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        nf_ce_n,
    output logic [1:0]  nf_cs,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic [7:0]  nf_dq_o,
    output logic        nf_dq_oe,
    input  logic [7:0]  nf_dq_i,
    input  logic        nf_rb_n
);
    logic [15:0]        cmd_q, adr_q;
    logic [1:0]         cs_q;
    logic [2:0]         idx_q;
    logic [7:0]         cfg_q;
    logic [NUM_OPS-1:0] ops_q;
    logic               done_q, start, clr, busy, op_done;
    op_e                op_sel;
    logic [7:0]         rx_byte;

    nand_eng_regs #(.SRST_CLKS(SRST_CLKS)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy_i(busy), .op_done_i(op_done),
        .cmd_q(cmd_q), .adr_q(adr_q), .cs_q(cs_q), .idx_q(idx_q),
        .cfg_q(cfg_q), .ops_q(ops_q), .done_q(done_q),
        .start_o(start), .op_o(op_sel), .clr_o(clr)
    );

    nand_eng_fsm #(
        .PAGE_BYTES(PAGE_BYTES), .ID_BYTES(ID_BYTES),
        .STROBE_CLKS(STROBE_CLKS), .TWB_CLKS(TWB_CLKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .op_in(op_sel),
        .cmd_byte(cmd_q[7:0]), .adr_byte(adr_q[7:0]), .buf_idx(idx_q),
        .rb_n(nf_rb_n), .dq_i(nf_dq_i),
        .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n), .re_n(nf_re_n),
        .dq_oe(nf_dq_oe), .dq_o(nf_dq_o), .busy(busy), .op_done(op_done),
        .rx_byte(rx_byte)
    );

    assign irq     = done_q && !cfg_q[4];
    assign nf_ce_n = !cfg_q[7];
    assign nf_cs   = cs_q;

    always_comb begin
        unique case (reg_addr)
            A_CMD:   reg_rdata = cmd_q;
            A_ADR:   reg_rdata = adr_q;
            A_BUF:   reg_rdata = {9'd0, cs_q, 2'd0, idx_q};
            A_TRIG:  reg_rdata = {done_q, 9'd0, ops_q};
            A_CFG:   reg_rdata = {8'd0, cfg_q};
            A_RX:    reg_rdata = {8'd0, rx_byte};
            default: reg_rdata = 16'd0;
        endcase
    end
endmodule

// File: tb/nand_op_engine_test.sv
`timescale 1ns/1ps
module nand_op_engine_test;
    localparam int PAGE   = 8;
    localparam int IDB    = 4;
    localparam int STROBE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [1:0]  nf_cs;
    logic [7:0]  nf_dq_o, nf_dq_i;
    logic        nf_rb_n = 1'b1;

    int errors = 0, checks = 0;
    int we_cnt = 0, re_cnt = 0, rd_idx = 0;
    bit mon_on = 0;
    time t_we, t_re;
    logic [9:0] expq[$];

    always #4 clk = ~clk;

    assign nf_dq_i = 8'hA0 + 8'(rd_idx);

    nand_op_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .nf_ce_n(nf_ce_n), .nf_cs(nf_cs), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o),
        .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb_n(nf_rb_n)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: write strobes against the scoreboard, R12 widths
    always @(negedge nf_we_n) t_we = $time;
    always @(negedge nf_re_n) t_re = $time;
    always @(posedge nf_we_n) if (mon_on) begin
        logic [9:0] got, want;
        we_cnt++;
        check_eq("R12 write strobe width", 32'($time - t_we), 32'(STROBE * 8));
        got = {nf_cle, nf_ale, nf_dq_o};
        if (expq.size() == 0) begin
            check_eq("R2/R4 unexpected write strobe", 32'(got), 32'h3ff);
        end else begin
            want = expq.pop_front();
            check_eq("R2/R3/R11 strobe item", 32'(got), 32'(want));
        end
    end
    always @(posedge nf_re_n) if (mon_on) begin
        re_cnt++;
        check_eq("R12 read strobe width", 32'($time - t_re), 32'(STROBE * 8));
        rd_idx++;
    end

    task automatic push(input logic c, input logic a, input logic [7:0] d);
        expq.push_back({c, a, d});
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input string tag);
        logic [15:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(3'd3, v);
            if (v[15]) return;
        end
        check_eq({tag, " completion timeout"}, 32'(v), 32'h8000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        // R1 reset state
        rd(3'd3, v); check_eq("R1 operation reg", 32'(v), 0);
        rd(3'd4, v); check_eq("R1 config reg", 32'(v), 0);
        check_eq("R1 pins ce/we/re/irq", {nf_ce_n, nf_we_n, nf_re_n, irq}, 4'b1110);

        // R9 chip enable, chip select, buffer index
        wr(3'd4, 16'h0080);
        wr(3'd2, 16'h0045);
        rd(3'd2, v); check_eq("R9 buffer select readback", 32'(v), 32'h45);
        check_eq("R9 ce_n/cs", {nf_ce_n, nf_cs}, 3'b010);

        // R2 command
        wr(3'd0, 16'h1290);
        push(1'b1, 1'b0, 8'h90);
        n0 = we_cnt;
        wr(3'd3, 16'h0001);
        wait_done("R2");
        rd(3'd3, v); check_eq("R6 flag set, op bits clear", 32'(v), 32'h8000);
        check_eq("R7 irq with mask off", 32'(irq), 1);
        check_eq("R2 one strobe", 32'(we_cnt - n0), 1);

        // R6 clear the flag
        wr(3'd3, 16'h0000);
        rd(3'd3, v); check_eq("R6 flag cleared by write of 0", 32'(v), 0);
        check_eq("R7 irq follows flag", 32'(irq), 0);

        // R3 address
        wr(3'd1, 16'h0123);
        push(1'b0, 1'b1, 8'h23);
        n0 = we_cnt;
        wr(3'd3, 16'h0002);
        wait_done("R3");
        check_eq("R3 one address byte", 32'(we_cnt - n0), 1);
        wr(3'd3, 16'h0000);

        // R5 / R10 busy behaviour with ready/busy low
        nf_rb_n = 1'b0;
        push(1'b1, 1'b0, 8'h90);
        wr(3'd3, 16'h0001);
        repeat (4) @(negedge clk);
        rd(3'd3, v); check_eq("R5 op bit reads back while busy", 32'(v), 32'h0001);
        wr(3'd0, 16'h0055);
        wr(3'd3, 16'h0004);
        repeat (50) @(negedge clk);
        rd(3'd3, v); check_eq("R10 no completion while busy line low", 32'(v), 32'h0001);
        nf_rb_n = 1'b1;
        wait_done("R10");
        rd(3'd0, v); check_eq("R5 write during busy ignored", 32'(v), 32'h1290);
        wr(3'd3, 16'h0000);

        // R4 priority: address + page in -> address only
        push(1'b0, 1'b1, 8'h23);
        n0 = we_cnt;
        wr(3'd3, 16'h0006);
        repeat (2) @(negedge clk);
        rd(3'd3, v); check_eq("R4 lowest op selected", 32'(v), 32'h0002);
        wait_done("R4");
        check_eq("R4 single strobe", 32'(we_cnt - n0), 1);
        wr(3'd3, 16'h0000);

        // R11 page in
        for (int i = 0; i < PAGE; i++) push(1'b0, 1'b0, {3'd5, 5'(i)});
        n0 = we_cnt;
        wr(3'd3, 16'h0004);
        wait_done("R11 page in");
        check_eq("R11 page-in strobe count", 32'(we_cnt - n0), PAGE);
        wr(3'd3, 16'h0000);

        // R11 page out
        rd_idx = 0; n0 = re_cnt;
        wr(3'd3, 16'h0008);
        wait_done("R11 page out");
        check_eq("R11 page-out read count", 32'(re_cnt - n0), PAGE);
        rd(3'd5, v); check_eq("R11 page-out last byte", 32'(v), 32'hA0 + PAGE - 1);
        wr(3'd3, 16'h0000);

        // R11 ID read
        rd_idx = 0; n0 = re_cnt;
        wr(3'd3, 16'h0010);
        wait_done("R11 id");
        check_eq("R11 id read count", 32'(re_cnt - n0), IDB);
        rd(3'd5, v); check_eq("R11 id last byte", 32'(v), 32'hA0 + IDB - 1);
        wr(3'd3, 16'h0000);

        // R7 masked status read
        wr(3'd4, 16'h0090);
        rd_idx = 0; n0 = re_cnt;
        wr(3'd3, 16'h0020);
        wait_done("R7");
        check_eq("R11 status single read", 32'(re_cnt - n0), 1);
        rd(3'd5, v); check_eq("R11 status byte", 32'(v), 32'hA0);
        check_eq("R7 irq masked, flag set", 32'(irq), 0);

        // R8 soft reset during a busy command, flag kept by bit15=1
        nf_rb_n = 1'b0;
        push(1'b1, 1'b0, 8'h90);
        wr(3'd3, 16'h8001);
        repeat (3) @(negedge clk);
        rd(3'd3, v); check_eq("R6 flag kept by write of 1", 32'(v), 32'h8001);
        wr(3'd4, 16'h0040);
        repeat (10) @(negedge clk);
        rd(3'd4, v); check_eq("R8 reset bit self-clears, config kept", 32'(v), 32'h0090);
        rd(3'd3, v); check_eq("R8 flag and op bits cleared", 32'(v), 0);
        nf_rb_n = 1'b1;
        repeat (10) @(negedge clk);
        rd(3'd3, v); check_eq("R8 engine stays idle", 32'(v), 0);
        check_eq("R8 strobes idle", {nf_we_n, nf_re_n}, 2'b11);

        check_eq("R2 scoreboard drained", 32'(expq.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule